// File: doc/BRIEF.md
# Dual-Path Interleaved Interpolating Filter

This block takes one complex stream of 16-bit I/Q samples and interpolates it with a polyphase FIR filter built from two identical half-rate engines. Samples accepted after a start pulse are dealt out alternately: the even-numbered ones go to engine A and the odd-numbered ones to engine B. Each engine sees half the input rate and so has twice the time per input to spend on taps. Each engine produces one polyphase output on every output tick and steps its phase index through 0..L-1. Engine B runs L/2 ticks behind engine A, which puts the two half a sub-stream period apart. A final stage adds the two engine outputs on each tick, rounds the sum, shifts it and saturates it back to 16 bits.

Both engines read one coefficient set. Software-style writes land in a staging bank, and a sync pulse copies that bank into the live bank that the engines read. The same sync pulse clears both delay lines and releases both engines from phase zero, so their relative timing is exact. The block pulls input through a valid/ready pair. On a tick that needs a sample and has none, the tick stalls.

Top module: `dual_interp_top`

## Requirements
- R1: After reset, out_valid, in_ready, ovf and both output words are zero. No tick happens and in_ready stays low until the first sync pulse.
- R2: A tick counter t counts the ticks since the last sync. in_ready is high exactly when the block is running and t mod L is 0 or L/2.
- R3: Samples accepted after a sync are numbered n = 0, 1, 2, ... Even n feed engine A, which accepts at t mod L = 0. Odd n feed engine B, which accepts at t mod L = L/2.
- R4: On tick t, engine A outputs sum over k of c[p+k*L]*A[m-k], where p = t mod L, m = floor(t/L), NPH = ceil(TAPS/L), k runs 0..NPH-1, and A[j] is sample 2j. Terms with a coefficient index of TAPS or more, or with m-k < 0, are zero.
- R5: Engine B uses the same formula on tB = t - L/2, with B[j] = sample 2j+1. It contributes zero while tB < 0.
- R6: out_valid goes high the cycle after a tick only if tB >= (NPH-1)*L on that tick, that is, only once engine B has received NPH samples.
- R7: The output is ((A + B + 2^(SHIFT-1)) >> SHIFT), using an arithmetic shift, saturated to the range -32768..32767, for I and Q separately.
- R8: ovf becomes 1 when a valid output saturates in I or Q. Only reset clears it.
- R9: While in_ready is high and in_valid is low, no tick happens: t holds and out_valid is low in the next cycle.
- R10: Coefficient writes go to a staging bank and do not change the outputs. The live coefficients take the staging contents only on a sync pulse. A write in the same cycle as a sync is not part of that copy.
- R11: A sync pulse clears both delay lines and the fill count, sets t to 0, overrides any tick in that cycle, and makes out_valid low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one output tick per advancing cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Start pulse: commits coefficients, restarts both engines |
| cw_en | input | 1 | Coefficient staging write enable |
| cw_addr | input | clog2(TAPS) | Coefficient staging address |
| cw_data | input | CW | Signed coefficient word |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block takes a sample this cycle |
| in_i | input | DW | Input sample, in-phase |
| in_q | input | DW | Input sample, quadrature |
| out_valid | output | 1 | Output word valid strobe |
| out_i | output | DW | Output sample, in-phase |
| out_q | output | DW | Output sample, quadrature |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that rst_n is held low for at least one edge before any sync, and that sync is a single-cycle pulse. in_valid may drop on any cycle, and the stall properties rely on in_valid and the data inputs changing only away from the clock edge. The stimulus keeps to these rules. It drops in_valid on a fixed cadence to force stalls on both engines' accept phases. It never writes a coefficient in the same cycle as a sync. It loads a saturating coefficient and sample set only after the moderate set has been checked against the model.

// File: rtl/dual_interp_pkg.sv
// Shared definitions for the dual-path interpolator.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package dual_interp_pkg;
    // Which half-rate engine a sample or result belongs to
    typedef enum logic {ENG_A = 1'b0, ENG_B = 1'b1} engine_e;

    // Width needed to index n items, never below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/dual_interp_coefs.sv
// Two-bank coefficient store: writes land in a staging bank,
// and commit copies staging into the live bank both engines read.
// Assumes commit is a single-cycle pulse; out-of-range writes are dropped.
module dual_interp_coefs #(
    parameter int CW   = 16,
    parameter int TAPS = 24,
    parameter int AW   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_data,
    input  logic                 commit,
    output logic signed [CW-1:0] live [TAPS]
);
    logic signed [CW-1:0] stage [TAPS];

    // Staging writes and commit into the live bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < TAPS; j++) begin
                stage[j] <= '0;
                live[j]  <= '0;
            end
        end else begin
            if (wr_en && (int'(wr_addr) < TAPS))
                stage[wr_addr] <= wr_data;
            if (commit)
                for (int j = 0; j < TAPS; j++)
                    live[j] <= stage[j];
        end
    end
endmodule

// File: rtl/dual_interp_path.sv
// One half-rate polyphase engine: keeps NPH past samples and, for the
// phase given, forms the sum of NPH coefficient-sample products.
// Assumes phase < L; a loaded sample counts as the newest term that tick.
module dual_interp_path #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int TAPS = 24,
    parameter int L    = 48,
    parameter int NPH  = 1,
    parameter int PW   = 6,
    parameter int ACCW = 33
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   adv,
    input  logic                   load,
    input  logic [PW-1:0]          phase,
    input  logic signed [DW-1:0]   x_i,
    input  logic signed [DW-1:0]   x_q,
    input  logic signed [CW-1:0]   coef [TAPS],
    output logic signed [ACCW-1:0] y_i,
    output logic signed [ACCW-1:0] y_q
);
    localparam int PADN = NPH * L;

    logic signed [DW-1:0]   line_i [NPH];
    logic signed [DW-1:0]   line_q [NPH];
    logic signed [DW-1:0]   cur_i  [NPH];
    logic signed [DW-1:0]   cur_q  [NPH];
    logic signed [CW-1:0]   cpad   [PADN];
    logic signed [CW-1:0]   cf     [NPH];
    logic signed [ACCW-1:0] prod_i [NPH];
    logic signed [ACCW-1:0] prod_q [NPH];

    // Zero-pad the coefficient set up to a whole number of phases
    for (genvar j = 0; j < PADN; j++) begin : g_pad
        if (j < TAPS) begin : g_real
            assign cpad[j] = coef[j];
        end else begin : g_zero
            assign cpad[j] = '0;
        end
    end

    // Sample window for this tick, and the coefficient for each term
    for (genvar k = 0; k < NPH; k++) begin : g_term
        if (k == 0) begin : g_new
            assign cur_i[k] = load ? x_i : line_i[0];
            assign cur_q[k] = load ? x_q : line_q[0];
        end else begin : g_old
            assign cur_i[k] = load ? line_i[k-1] : line_i[k];
            assign cur_q[k] = load ? line_q[k-1] : line_q[k];
        end
        assign cf[k]     = cpad[int'(phase) + k*L];
        assign prod_i[k] = cur_i[k] * cf[k];
        assign prod_q[k] = cur_q[k] * cf[k];
    end

    // Accumulate the products of all terms
    always_comb begin
        y_i = '0;
        y_q = '0;
        for (int k = 0; k < NPH; k++) begin
            y_i = y_i + prod_i[k];
            y_q = y_q + prod_q[k];
        end
    end

    // Shift a newly accepted sample into the delay line
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int k = 0; k < NPH; k++) begin
                line_i[k] <= '0;
                line_q[k] <= '0;
            end
        end else if (adv && load) begin
            line_i[0] <= x_i;
            line_q[0] <= x_q;
            for (int k = NPH-1; k >= 1; k--) begin
                line_i[k] <= line_i[k-1];
                line_q[k] <= line_q[k-1];
            end
        end
    end
endmodule

// File: rtl/dual_interp_sum.sv
// Output stage: adds the two engine results, rounds half up, shifts,
// saturates to DW bits, registers the word and keeps a sticky flag.
// Assumes SHIFT >= 1 and that the sum fits in ACCW+2 bits.
module dual_interp_sum #(
    parameter int DW    = 16,
    parameter int ACCW  = 33,
    parameter int SHIFT = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   adv,
    input  logic                   emit,
    input  logic signed [ACCW-1:0] a_i,
    input  logic signed [ACCW-1:0] a_q,
    input  logic signed [ACCW-1:0] b_i,
    input  logic signed [ACCW-1:0] b_q,
    output logic                   out_valid,
    output logic signed [DW-1:0]   out_i,
    output logic signed [DW-1:0]   out_q,
    output logic                   ovf
);
    localparam int SW = ACCW + 2;
    localparam logic signed [SW-1:0] ONE  = 1;
    localparam logic signed [SW-1:0] HALF = ONE <<< (SHIFT-1);
    localparam logic signed [SW-1:0] MAXV = (ONE <<< (DW-1)) - ONE;
    localparam logic signed [SW-1:0] MINV = -(ONE <<< (DW-1));

    logic signed [SW-1:0] s_i, s_q, r_i, r_q;
    logic signed [DW-1:0] w_i, w_q;
    logic                 clip_i, clip_q;

    // Round, shift and clamp both components
    always_comb begin
        s_i = a_i + b_i;
        s_q = a_q + b_q;
        r_i = (s_i + HALF) >>> SHIFT;
        r_q = (s_q + HALF) >>> SHIFT;
        clip_i = (r_i > MAXV) || (r_i < MINV);
        clip_q = (r_q > MAXV) || (r_q < MINV);
        w_i = (r_i > MAXV) ? MAXV[DW-1:0] : (r_i < MINV) ? MINV[DW-1:0] : r_i[DW-1:0];
        w_q = (r_q > MAXV) ? MAXV[DW-1:0] : (r_q < MINV) ? MINV[DW-1:0] : r_q[DW-1:0];
    end

    // Register the output word, its strobe and the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            ovf       <= 1'b0;
        end else if (clear) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= adv && emit;
            if (adv && emit) begin
                out_i <= w_i;
                out_q <= w_q;
                ovf   <= ovf || clip_i || clip_q;
            end
        end
    end
endmodule

// File: rtl/dual_interp_top.sv
// Dual-path interleaved interpolator: deals samples alternately to two
// identical polyphase engines offset by L/2 ticks and sums their outputs.
// Assumes L even and at least 2, TAPS at least 2, sync a one-cycle pulse.
module dual_interp_top #(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int TAPS  = 24,
    parameter int L     = 48,
    parameter int SHIFT = 15,
    localparam int AW   = dual_interp_pkg::idx_w(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync,
    input  logic                 cw_en,
    input  logic [AW-1:0]        cw_addr,
    input  logic signed [CW-1:0] cw_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q,
    output logic                 ovf
);
    import dual_interp_pkg::*;

    localparam int H    = L / 2;
    localparam int NPH  = (TAPS + L - 1) / L;
    localparam int PW   = idx_w(L);
    localparam int FW   = idx_w(NPH + 1);
    localparam int ACCW = DW + CW + $clog2(NPH) + 1;

    logic                   running;
    logic [PW-1:0]          ph, ph_b;
    logic [FW-1:0]          bcnt;
    logic                   need, adv, emit;
    logic                   load [2];
    logic signed [CW-1:0]   live [TAPS];
    logic signed [ACCW-1:0] y_i [2];
    logic signed [ACCW-1:0] y_q [2];

    // Tick control: a tick needing a sample waits for in_valid
    always_comb begin
        need          = running && (ph == PW'(0) || ph == PW'(H));
        in_ready      = need;
        adv           = running && !sync && (!need || in_valid);
        load[ENG_A]   = adv && (ph == PW'(0));
        load[ENG_B]   = adv && (ph == PW'(H));
        ph_b          = (ph >= PW'(H)) ? ph - PW'(H) : ph + PW'(H);
        emit          = (bcnt == FW'(NPH)) || ((ph == PW'(H)) && (bcnt == FW'(NPH-1)));
    end

    // Phase counter, run flag and engine B fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            ph      <= '0;
            bcnt    <= '0;
        end else if (sync) begin
            running <= 1'b1;
            ph      <= '0;
            bcnt    <= '0;
        end else if (adv) begin
            ph <= (ph == PW'(L-1)) ? '0 : ph + PW'(1);
            if (load[ENG_B] && bcnt != FW'(NPH))
                bcnt <= bcnt + FW'(1);
        end
    end

    dual_interp_coefs #(.CW(CW), .TAPS(TAPS), .AW(AW)) u_coefs (
        .clk(clk), .rst_n(rst_n), .wr_en(cw_en), .wr_addr(cw_addr),
        .wr_data(cw_data), .commit(sync), .live(live)
    );

    for (genvar e = 0; e < 2; e++) begin : g_eng
        dual_interp_path #(
            .DW(DW), .CW(CW), .TAPS(TAPS), .L(L), .NPH(NPH), .PW(PW), .ACCW(ACCW)
        ) u_path (
            .clk(clk), .rst_n(rst_n), .clear(sync), .adv(adv), .load(load[e]),
            .phase((e == 0) ? ph : ph_b), .x_i(in_i), .x_q(in_q), .coef(live),
            .y_i(y_i[e]), .y_q(y_q[e])
        );
    end

    dual_interp_sum #(.DW(DW), .ACCW(ACCW), .SHIFT(SHIFT)) u_sum (
        .clk(clk), .rst_n(rst_n), .clear(sync), .adv(adv), .emit(emit),
        .a_i(y_i[ENG_A]), .a_q(y_q[ENG_A]), .b_i(y_i[ENG_B]), .b_q(y_q[ENG_B]),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .ovf(ovf)
    );
endmodule

// File: rtl/dual_interp_checker.sv
// Protocol and sequencing properties for dual_interp_top, bound to it.
// Assumes a synchronous active-low reset held for at least one edge.
module dual_interp_checker #(
    parameter int L  = 48,
    parameter int PW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          ovf,
    input logic          running,
    input logic [PW-1:0] ph
);
    // R2: ready only while running, on an accept phase
    a_r2_ready_phase: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (running && (ph == PW'(0) || ph == PW'(L/2))));

    // R1: nothing moves before the first sync
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!in_ready && !out_valid));

    // R8: saturation flag never drops without reset
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R9: a starved tick yields no output and holds the phase
    a_r9_stall_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && !sync) |=> !out_valid);
    a_r9_stall_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && !sync) |=> $stable(ph));

    // R11: sync restarts the phase and suppresses the next output
    a_r11_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (!out_valid && ph == PW'(0) && running));
endmodule

bind dual_interp_top dual_interp_checker #(.L(L), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync(sync), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .ovf(ovf),
    .running(running), .ph(ph)
);

// File: tb/dual_interp_top_test.sv
// Cycle-by-cycle behavioural model of the interpolator, compared on
// every clock. Inputs change and outputs are sampled on the falling edge.
module dual_interp_top_test;
    localparam int DW = 16, CW = 16, TAPS = 7, L = 4, SHIFT = 15;
    localparam int H = L / 2;
    localparam int NPH = (TAPS + L - 1) / L;
    localparam int AW = $clog2(TAPS);

    logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, cw_en = 1'b0, in_valid = 1'b0;
    logic [AW-1:0] cw_addr = '0;
    logic signed [CW-1:0] cw_data = '0;
    logic signed [DW-1:0] in_i = '0, in_q = '0;
    logic in_ready, out_valid, ovf;
    logic signed [DW-1:0] out_i, out_q;

    dual_interp_top #(.DW(DW), .CW(CW), .TAPS(TAPS), .L(L), .SHIFT(SHIFT)) uut (
        .clk(clk), .rst_n(rst_n), .sync(sync), .cw_en(cw_en), .cw_addr(cw_addr),
        .cw_data(cw_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i),
        .out_q(out_q), .ovf(ovf)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    // model state
    longint smp_i [0:1023];
    longint smp_q [0:1023];
    int  ns = 0, t = 0, epoch = 0;
    bit  run = 1'b0;
    int  cm [TAPS];
    int  stg [TAPS];
    bit  e_valid = 1'b0, e_ovf = 1'b0, e_ready = 1'b0, e_sat = 1'b0;
    int  e_i = 0, e_q = 0;
    bit  was_stall = 1'b0, rewrite = 1'b0, after_sync = 1'b0;
    int  e_t = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic longint engine(input bit isb, input bit isq);
        longint acc = 0;
        int tt = isb ? t - H : t;
        if (tt < 0) return 0;
        for (int k = 0; k < NPH; k++) begin
            int idx = (tt % L) + k * L;
            int j = tt / L - k;
            if (idx < TAPS && j >= 0)
                acc += longint'(cm[idx]) * (isq ? smp_q[2*j + isb] : smp_i[2*j + isb]);
        end
        return acc;
    endfunction

    function automatic int rsat(input longint s, output bit clip);
        longint r = (s + (longint'(1) <<< (SHIFT-1))) >>> SHIFT;
        clip = (r > 32767) || (r < -32768);
        return (r > 32767) ? 32767 : (r < -32768) ? -32768 : int'(r);
    endfunction

    function automatic int gen(input int n, input bit q);
        if (epoch == 2) return q ? ((n % 2 == 0) ? -31000 : 29000) : 30000 - (n % 3) * 100;
        return q ? ((n * 4111 + 77) % 36000) - 18000 : ((n * 7919) % 40000) - 20000;
    endfunction

    // One falling edge: compare, drive, then predict the next rising edge
    task automatic step(input bit s, input bit we, input int addr, input int data, input bit v);
        string tag;
        @(negedge clk);
        cyc++;
        tag = after_sync ? "R11" : (was_stall ? "R9" : "R6");
        check(out_valid === e_valid, tag, out_valid, e_valid);
        check(in_ready === e_ready, "R2", in_ready, e_ready);
        check(ovf === e_ovf, "R8", ovf, e_ovf);
        if (e_valid) begin
            tag = e_sat ? "R7" : rewrite ? "R10" : (e_t < H + L) ? "R5" : (e_t < 3 * L) ? "R3" : "R4";
            check(out_i === DW'(e_i), tag, out_i, e_i);
            check(out_q === DW'(e_q), tag, out_q, e_q);
        end
        sync = s; cw_en = we; cw_addr = AW'(addr); cw_data = CW'(data); in_valid = v;
        in_i = DW'(gen(ns, 1'b0)); in_q = DW'(gen(ns, 1'b1));
        was_stall = 1'b0; after_sync = 1'b0;
        if (s) begin
            for (int j = 0; j < TAPS; j++) cm[j] = stg[j];
            t = 0; ns = 0; run = 1'b1; e_valid = 1'b0; after_sync = 1'b1; rewrite = 1'b0;
        end else if (run) begin
            bit nd = (t % L == 0) || (t % L == H);
            if (nd && !v) begin
                e_valid = 1'b0; was_stall = 1'b1;
            end else begin
                bit ci, cq;
                if (nd) begin smp_i[ns] = in_i; smp_q[ns] = in_q; ns++; end
                e_valid = (t - H) >= (NPH - 1) * L;
                if (e_valid) begin
                    e_i = rsat(engine(1'b0, 1'b0) + engine(1'b1, 1'b0), ci);
                    e_q = rsat(engine(1'b0, 1'b1) + engine(1'b1, 1'b1), cq);
                    e_sat = ci || cq;
                    e_ovf = e_ovf || e_sat;
                    e_t = t;
                end
                t++;
            end
        end
        if (we && addr < TAPS) begin stg[addr] = data; if (run) rewrite = 1'b1; end
        e_ready = run && ((t % L == 0) || (t % L == H));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int set1 [TAPS] = '{8192, -4096, 16384, 3000, -12000, 20000, 5000};
        for (int j = 0; j < TAPS; j++) stg[j] = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(out_valid === 1'b0 && in_ready === 1'b0 && ovf === 1'b0, "R1", out_valid, 0);
        check(out_i === '0 && out_q === '0, "R1", out_i, 0);
        rst_n = 1'b1;
        // R1: idle until sync, coefficient loading
        for (int j = 0; j < TAPS; j++) step(1'b0, 1'b1, j, set1[j], 1'b1);
        repeat (4) step(1'b0, 1'b0, 0, 0, 1'b1);
        epoch = 1;
        step(1'b1, 1'b0, 0, 0, 1'b0);
        // R3-R6, R9: run with periodic starvation
        for (int c = 0; c < 160; c++) step(1'b0, 1'b0, 0, 0, (c % 5) != 2);
        // R10: rewrite coefficients while running; no effect until sync
        for (int j = 0; j < TAPS; j++) step(1'b0, 1'b1, j, 32767 - j * 10, 1'b1);
        for (int c = 0; c < 40; c++) step(1'b0, 1'b0, 0, 0, (c % 7) != 4);
        // R11, R7, R8: restart with saturating data
        epoch = 2;
        step(1'b1, 1'b0, 0, 0, 1'b1);
        for (int c = 0; c < 60; c++) step(1'b0, 1'b0, 0, 0, (c % 6) != 1);
        // R8: flag stays set after returning to moderate data
        epoch = 1;
        for (int j = 0; j < TAPS; j++) step(1'b0, 1'b1, j, set1[j], 1'b1);
        step(1'b1, 1'b0, 0, 0, 1'b1);
        for (int c = 0; c < 40; c++) step(1'b0, 1'b0, 0, 0, 1'b1);
        check(ovf === 1'b1, "R8", ovf, 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule